// File: doc/BRIEF.md
# Pipelined CORDIC sine and cosine generator

This block turns a stream of signed angles into matching cosine and sine samples. It is meant to feed the reference input of a PWM generator. A new angle may enter on every clock. Each angle passes through a chain of rotation-mode CORDIC iterations, one register stage per iteration. A fixed number of clocks later the pair of results leaves the last stage. The first stage starts from a pre-scaled X value, so the outputs need no gain correction.

Every iteration has to divide X and Y by a power of two. The shift amount grows by one per stage, and the last stage shifts by one less than the word width. A plain arithmetic right shift rounds toward minus infinity, so a negative operand does not mirror its positive twin. This block therefore shifts symmetrically: it takes the magnitude, shifts it, and restores the sign, which rounds toward zero. Each stage also picks its rotation direction in a mirror-consistent way when the residual angle is exactly zero. Together these make cos(+a) equal cos(−a) bit for bit, and sin(+a) equal −sin(−a).

Angles are two's complement, with the full code range spanning one turn. The supported input range is −45° to +45°. Outputs are signed, with unity scaled to 2^(DW−2).

Top module: `cordic_wave_gen`

## Requirements
- R1: A sample captured on a rising edge (inValid high, rst low) produces outValid and its results after exactly NSTG rising edges, counting the capturing edge. With the defaults (DW = 16, NSTG = 16) this is 16 edges.
- R2: Each accepted angle yields exactly one output sample, and samples leave in the order they entered. Gaps in inValid are reproduced as gaps in outValid, and outValid never rises without a matching accepted input.
- R3: rst is synchronous. On the edge where rst is high, every in-flight valid bit is cleared, so outValid is low after that edge. No sample that was in flight, or that was presented while rst was high, ever emerges.
- R4: The angle code is two's complement, and 2^DW codes make 360°, so 45° is code 8192 at the defaults. Unity output is 2^(DW−2), which is 16384 at the defaults. For every angle in [−8192, +8192], cosOut and sinOut are each within 16 LSB of 16384·cos and 16384·sin of that angle.
- R5: For every angle a in the supported range, cosOut for −a is bit-identical to cosOut for +a.
- R6: For every nonzero angle a in the supported range, sinOut for −a is the exact two's-complement negation of sinOut for +a.
- R7: When inValid is low and no valid sample is in flight, cosOut and sinOut hold their last values. An angle presented with inValid low never reaches the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, clears all valid bits |
| inValid | input | 1 | Qualifies angleIn on this edge |
| angleIn | input | DW | Signed angle, 2^DW codes per turn |
| outValid | output | 1 | cosOut and sinOut hold a finished sample |
| cosOut | output | DW | Signed cosine, unity = 2^(DW−2) |
| sinOut | output | DW | Signed sine, unity = 2^(DW−2) |

## Verification
The hardest case to reach is one where two mirrored angles could part ways by a single LSB. That needs a negative X or Y term to be truncated at some deep stage, or a residual angle that lands exactly on zero, and neither is visible at the ports. The stimulus therefore sends every supported angle magnitude as a back-to-back pair, +a then −a, so every such event in the range occurs in at least one pair. Each consecutive pair of outputs is compared bit-exactly, and each sample is also checked against a real-valued cosine and sine. A reset is issued while the pipeline is half full, and idle cycles carry junk angles, to show that discarded samples never surface.

// File: rtl/cordic_wave_pkg.sv
package cordic_wave_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // first stage loads a new angle
    logic busy;     // some valid sample still has stages to cross
  } pipeStrobe_t;

  localparam real PI_R = 3.14159265358979323846;

  // 2^-n as a real
  function automatic real powHalf(input int n);
    real r;
    r = 1.0;
    for (int j = 0; j < n; j++) r = r / 2.0;
    return r;
  endfunction

  // 2^n as a real
  function automatic real powTwo(input int n);
    real r;
    r = 1.0;
    for (int j = 0; j < n; j++) r = r * 2.0;
    return r;
  endfunction

  // arctangent for 0 < x <= 1 by power series (x = 1 handled exactly)
  function automatic real seriesAtan(input real x);
    real acc;
    real term;
    real x2;
    if (x >= 1.0) return PI_R / 4.0;
    acc  = 0.0;
    term = x;
    x2   = x * x;
    for (int k = 0; k < 80; k++) begin
      if ((k % 2) == 0) acc = acc + term / real'(2 * k + 1);
      else              acc = acc - term / real'(2 * k + 1);
      term = term * x2;
    end
    return acc;
  endfunction

  // atan(2^-idx) in angle codes, 2^angW codes per turn, rounded
  function automatic int atanCode(input int idx, input int angW);
    real r;
    r = seriesAtan(powHalf(idx)) / (2.0 * PI_R) * powTwo(angW);
    return $rtoi(r + 0.5);
  endfunction

  function automatic real sqrtReal(input real v);
    real y;
    y = 1.0;
    for (int j = 0; j < 40; j++) y = (y + v / y) / 2.0;
    return y;
  endfunction

  // product of 1/sqrt(1 + 4^-i) over all stages
  function automatic real invGain(input int nStage);
    real g;
    g = 1.0;
    for (int i = 0; i < nStage; i++) g = g / sqrtReal(1.0 + powHalf(2 * i));
    return g;
  endfunction

  // pre-scaled start value for X, unity = 2^(w-2)
  function automatic int xInitCode(input int nStage, input int w);
    return $rtoi(invGain(nStage) * powTwo(w - 2) + 0.5);
  endfunction

endpackage

// File: rtl/cordic_wave_symshr.sv
// Divide by 2^SH, rounding toward zero, so +v and -v give mirrored results.
module cordic_wave_symshr #(
  parameter int W  = 16,
  parameter int SH = 0
) (
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout
);
  logic         isNeg;
  logic [W-1:0] magnitude;
  logic [W-1:0] shifted;

  always_comb begin
    isNeg     = din[W-1];
    magnitude = isNeg ? W'(-din) : W'(din);
    shifted   = magnitude >> SH;
    dout      = isNeg ? -signed'(shifted) : signed'(shifted);
  end
endmodule

// File: rtl/cordic_wave_stage.sv
// One CORDIC iteration with its output register.
module cordic_wave_stage
  import cordic_wave_pkg::*;
#(
  parameter int W   = 16,
  parameter int IDX = 0
) (
  input  logic                clk,
  input  logic                en,
  input  logic signed [W-1:0] xIn,
  input  logic signed [W-1:0] yIn,
  input  logic signed [W-1:0] zIn,
  input  logic                mirIn,
  output logic signed [W-1:0] xOut,
  output logic signed [W-1:0] yOut,
  output logic signed [W-1:0] zOut,
  output logic                mirOut
);
  localparam logic signed [W-1:0] STEP = W'(atanCode(IDX, W));

  logic signed [W-1:0] xShr;
  logic signed [W-1:0] yShr;
  logic signed [W-1:0] xNext;
  logic signed [W-1:0] yNext;
  logic signed [W-1:0] zNext;
  logic                zZero;
  logic                turnPos;

  cordic_wave_symshr #(.W(W), .SH(IDX)) u_shrX (.din(xIn), .dout(xShr));
  cordic_wave_symshr #(.W(W), .SH(IDX)) u_shrY (.din(yIn), .dout(yShr));

  always_comb begin
    zZero = (zIn == '0);
    // positive residual turns positive; an exact zero follows the sample's
    // mirror flag so +a and -a always pick opposite directions
    turnPos = (!zIn[W-1] && !zZero) || (zZero && !mirIn);
    if (turnPos) begin
      xNext = xIn - yShr;
      yNext = yIn + xShr;
      zNext = zIn - STEP;
    end else begin
      xNext = xIn + yShr;
      yNext = yIn - xShr;
      zNext = zIn + STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      xOut   <= xNext;
      yOut   <= yNext;
      zOut   <= zNext;
      mirOut <= mirIn;
    end
  end
endmodule

// File: rtl/cordic_wave_dp.sv
// Rotation chain: one registered stage per iteration.
module cordic_wave_dp
  import cordic_wave_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NSTG = DW
) (
  input  logic                 clk,
  input  pipeStrobe_t          strb,
  input  logic signed [DW-1:0] angleIn,
  output logic signed [DW-1:0] cosOut,
  output logic signed [DW-1:0] sinOut
);
  localparam logic signed [DW-1:0] X_INIT = DW'(xInitCode(NSTG, DW));
  localparam logic signed [DW-1:0] Y_INIT = '0;

  logic signed [DW-1:0] xS   [NSTG];
  logic signed [DW-1:0] yS   [NSTG];
  logic signed [DW-1:0] zS   [NSTG];
  logic                 mirS [NSTG];

  for (genvar k = 0; k < NSTG; k++) begin : g_stage
    if (k == 0) begin : g_head
      cordic_wave_stage #(.W(DW), .IDX(0)) u_stg (
        .clk    (clk),
        .en     (strb.capture),
        .xIn    (X_INIT),
        .yIn    (Y_INIT),
        .zIn    (angleIn),
        .mirIn  (angleIn[DW-1]),
        .xOut   (xS[0]),
        .yOut   (yS[0]),
        .zOut   (zS[0]),
        .mirOut (mirS[0])
      );
    end else begin : g_body
      cordic_wave_stage #(.W(DW), .IDX(k)) u_stg (
        .clk    (clk),
        .en     (strb.busy),
        .xIn    (xS[k-1]),
        .yIn    (yS[k-1]),
        .zIn    (zS[k-1]),
        .mirIn  (mirS[k-1]),
        .xOut   (xS[k]),
        .yOut   (yS[k]),
        .zOut   (zS[k]),
        .mirOut (mirS[k])
      );
    end
  end

  assign cosOut = xS[NSTG-1];
  assign sinOut = yS[NSTG-1];
endmodule

// File: rtl/cordic_wave_ctl.sv
// Valid tracking and stage enables.
module cordic_wave_ctl
  import cordic_wave_pkg::*;
#(
  parameter int NSTG = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output pipeStrobe_t strb,
  output logic        outValid
);
  logic [NSTG-1:0] vld;

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= {vld[NSTG-2:0], inValid};
  end

  always_comb begin
    strb.capture = inValid;
    strb.busy    = |vld[NSTG-2:0];
  end

  assign outValid = vld[NSTG-1];
endmodule

// File: rtl/cordic_wave_gen.sv
module cordic_wave_gen
  import cordic_wave_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NSTG = DW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic signed [DW-1:0] angleIn,
  output logic                 outValid,
  output logic signed [DW-1:0] cosOut,
  output logic signed [DW-1:0] sinOut
);
  pipeStrobe_t strb;

  cordic_wave_ctl #(.NSTG(NSTG)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strb     (strb),
    .outValid (outValid)
  );

  cordic_wave_dp #(.DW(DW), .NSTG(NSTG)) u_dp (
    .clk     (clk),
    .strb    (strb),
    .angleIn (angleIn),
    .cosOut  (cosOut),
    .sinOut  (sinOut)
  );
endmodule

// File: rtl/cordic_wave_chk.sv
module cordic_wave_chk #(
  parameter int DW   = 16,
  parameter int NSTG = DW
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 inValid,
  input logic                 outValid,
  input logic signed [DW-1:0] cosOut,
  input logic signed [DW-1:0] sinOut,
  input logic                 busy
);
  localparam int LIMIT = (1 << (DW - 2)) + 16;

  int inFlight;

  always_ff @(posedge clk) begin
    if (rst) inFlight <= 0;
    else     inFlight <= inFlight + (inValid ? 1 : 0) - (outValid ? 1 : 0);
  end

  // R3: reset leaves nothing valid
  a_r3_reset_clears: assert property (@(posedge clk) rst |=> !outValid);

  // R2: no output without an accepted input still owed
  a_r2_no_phantom: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (inFlight > 0));

  // R2: never more samples owed than stages exist
  a_r2_depth: assert property (@(posedge clk) disable iff (rst)
    inFlight <= NSTG);

  // R4: results stay within unity plus margin
  a_r4_bounded: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (cosOut <= LIMIT && cosOut >= -LIMIT &&
                  sinOut <= LIMIT && sinOut >= -LIMIT));

  // R7: idle pipeline holds its outputs
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !inValid) |=> ($stable(cosOut) && $stable(sinOut)));
endmodule

bind cordic_wave_gen cordic_wave_chk #(.DW(DW), .NSTG(NSTG)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .outValid (outValid),
  .cosOut   (cosOut),
  .sinOut   (sinOut),
  .busy     (strb.busy)
);

// File: tb/sim_cordic_wave_gen.sv
`timescale 1ns/1ps
module sim_cordic_wave_gen;
  localparam int  DW   = 16;
  localparam int  NSTG = DW;
  localparam int  UNIT = 1 << (DW - 2);
  localparam int  TOL  = 16;
  localparam int  QMAX = 1 << (DW - 3);
  localparam real PI_B = 3.14159265358979323846;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 inValid = 1'b0;
  logic signed [DW-1:0] angleIn = '0;
  logic                 outValid;
  logic signed [DW-1:0] cosOut;
  logic signed [DW-1:0] sinOut;

  int checks = 0;
  int fails = 0;
  int cnt = 0;
  int inCount = 0;
  int outCount = 0;
  int angQ[$];
  int cycQ[$];
  bit havePrev = 1'b0;
  int prevAng = 0;
  int prevCos = 0;
  int prevSin = 0;

  cordic_wave_gen #(.DW(DW), .NSTG(NSTG)) u0 (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .angleIn  (angleIn),
    .outValid (outValid),
    .cosOut   (cosOut),
    .sinOut   (sinOut)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cnt <= cnt + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int roundR(input real r);
    if (r >= 0.0) return $rtoi(r + 0.5);
    return -$rtoi(-r + 0.5);
  endfunction

  function automatic int absI(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic drive(input int ang, input bit v);
    @(negedge clk);
    inValid = v;
    angleIn = DW'(ang);
    if (v && !rst) begin
      angQ.push_back(ang);
      cycQ.push_back(cnt + 1);
      inCount++;
    end
  endtask

  // output monitor
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (angQ.size() == 0) begin
        check(1'b0, "R2", "outValid with no accepted input", 1, 0);
      end else begin
        int  a;
        int  c0;
        int  ec;
        int  es;
        real th;
        a  = angQ.pop_front();
        c0 = cycQ.pop_front();
        outCount++;
        check((cnt - c0) == NSTG - 1, "R1", "edges from capture to output",
              cnt - c0 + 1, NSTG);
        th = real'(a) * 2.0 * PI_B / real'(1 << DW);
        ec = roundR(real'(UNIT) * $cos(th));
        es = roundR(real'(UNIT) * $sin(th));
        check(absI(int'(cosOut) - ec) <= TOL, "R4", "cosine", int'(cosOut), ec);
        check(absI(int'(sinOut) - es) <= TOL, "R4", "sine", int'(sinOut), es);
        if (havePrev && a != 0 && a == -prevAng) begin
          check(int'(cosOut) == prevCos, "R5", "cos(-a) vs cos(+a)",
                int'(cosOut), prevCos);
          check(int'(sinOut) == -prevSin, "R6", "sin(-a) vs -sin(+a)",
                int'(sinOut), -prevSin);
        end
        havePrev = 1'b1;
        prevAng  = a;
        prevCos  = int'(cosOut);
        prevSin  = int'(sinOut);
      end
    end
  end

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  // watchdog
  initial begin
    #(4 * 100000);
    check(1'b0, "R1", "watchdog expired", cnt, 0);
    finishRun();
  end

  initial begin
    int holdCos;
    int holdSin;
    bit sawValid;

    // R3: reset state
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R3", "outValid during reset", int'(outValid), 0);
    rst = 1'b0;

    // R2: directed angles with gaps, including both range ends
    drive(0, 1'b1);
    drive(0, 1'b0);
    drive(QMAX, 1'b1);
    drive(-QMAX, 1'b1);
    repeat (3) drive(0, 1'b0);
    drive(QMAX / 2, 1'b1);
    drive(0, 1'b0);
    drive(-(QMAX / 2), 1'b1);
    drive(1, 1'b1);
    drive(-1, 1'b1);
    repeat (NSTG + 4) drive(0, 1'b0);
    check(angQ.size() == 0, "R2", "samples still owed after gaps",
          angQ.size(), 0);
    check(outCount == inCount, "R2", "outputs vs inputs with gaps",
          outCount, inCount);

    // R5 R6 R4: every magnitude as a +a / -a pair, back to back
    for (int a = 1; a <= QMAX; a++) begin
      drive(a, 1'b1);
      drive(-a, 1'b1);
    end
    repeat (NSTG + 4) drive(0, 1'b0);
    check(angQ.size() == 0, "R2", "samples still owed after sweep",
          angQ.size(), 0);
    check(outCount == inCount, "R2", "outputs vs inputs after sweep",
          outCount, inCount);

    // R7: junk angles with inValid low must not disturb the outputs
    holdCos  = int'(cosOut);
    holdSin  = int'(sinOut);
    sawValid = 1'b0;
    for (int i = 0; i < 24; i++) begin
      drive(int'($urandom_range(0, 65535)) - 32768, 1'b0);
      if (outValid) sawValid = 1'b1;
    end
    check(!sawValid, "R7", "outValid with inValid low", int'(sawValid), 0);
    check(int'(cosOut) == holdCos, "R7", "cosOut held", int'(cosOut), holdCos);
    check(int'(sinOut) == holdSin, "R7", "sinOut held", int'(sinOut), holdSin);

    // R3: reset with the pipeline half full, plus a sample during reset
    for (int i = 1; i <= NSTG / 2; i++) drive(i * 300, 1'b1);
    @(negedge clk);
    rst     = 1'b1;
    inValid = 1'b1;
    angleIn = DW'(1234);
    angQ.delete();
    cycQ.delete();
    inCount = outCount;
    @(negedge clk);
    rst     = 1'b0;
    inValid = 1'b0;
    sawValid = 1'b0;
    for (int i = 0; i < NSTG + 6; i++) begin
      drive(0, 1'b0);
      if (outValid) sawValid = 1'b1;
    end
    check(!sawValid, "R3", "discarded samples emerged", int'(sawValid), 0);

    // R1: pipeline works again after reset
    drive(QMAX / 4, 1'b1);
    drive(-(QMAX / 4), 1'b1);
    repeat (NSTG + 4) drive(0, 1'b0);
    check(outCount == inCount, "R1", "outputs after reset recovery",
          outCount, inCount);

    finishRun();
  end
endmodule